// File: doc/BRIEF.md
# Two-Area Asynchronous DRAM Sequencer

This block runs the strobe timing for up to two banks of asynchronous DRAM, each with its own row strobe. An internal master presents one request at a time: area, row/column address, direction and two byte enables. The block walks the access through a fixed chain of named phases. A row phase drives the row address with the area's row strobe low. A column phase follows, then column-strobe cycles, then a release cycle that signals completion. The row phase and the column-strobe phase can each be stretched by one clock, set by configuration inputs.

With page mode enabled, the row strobe stays low after an access. A later request for the same area and row skips the row phase. Any other request first precharges. Two strobe wirings are selectable. In one, there are two column strobes (one per byte lane) and a shared write enable. In the other, there is one column strobe and two byte write strobes. An interval counter schedules column-before-row refresh cycles, which wait for the current access and close an open page first. A self-refresh request parks both banks in the refresh strobe pattern until it is withdrawn.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While and after reset, every strobe output (ras_n, cas_lo_n, cas_hi_n, we_n) is all ones, ack is 0 and dram_addr is 0.
- R2: A request taken while idle drives the selected area's ras_n bit low (area 0 to bit 0, area 1 to bit 1) with dram_addr = req_addr[17:8] (row) in the first cycle after acceptance. It drives dram_addr = req_addr[7:0] (column) from the second cycle, column strobes in the third and fourth cycles, and ack = 1 with all column and write strobes high in the fifth. With page mode off, ras_n is all ones in the following cycle.
- R3: With cfg_q1_ext = 1 the row phase lasts two cycles instead of one.
- R4: With cfg_q4_ext = 1 the column-strobe phase lasts three cycles instead of two.
- R5: With cfg_strobe_mode = 0, during the column-strobe cycles cas_lo_n of the area is low when req_be[0] = 1, and cas_hi_n is low when req_be[1] = 1. we_n is low only for a write (req_write = 1).
- R6: With cfg_strobe_mode = 1, cas_lo_n of the area is the single column strobe, low for any access. we_n is the low-lane write strobe (write and req_be[0]) and cas_hi_n is the high-lane write strobe (write and req_be[1]).
- R7: With cfg_page_en = 1, ras_n stays low after ack. A request to the same area and row then drives the column address in the first cycle, column strobes in the second and third, and ack in the fourth, with the row strobe never released.
- R8: With a page open, a request to another row or area, or clearing cfg_page_en, releases ras_n to all ones for two cycles. A request then runs as in R2.
- R9: While cfg_ref_en = 1, a refresh becomes pending every cfg_ref_reload+1 cycles. Starting from idle, the first refresh cycle follows enabling by cfg_ref_reload+2 cycles. A refresh drives all column strobes low with ras_n high in cycle 1, all low in cycle 2, and ras_n low with column strobes high in cycle 3. Cycle 4 releases everything. In mode 1 cas_hi_n stays high.
- R10: A pending refresh waits for the access in progress to reach ack and, if a page is open, for a two-cycle precharge.
- R11: With cfg_self_ref = 1 in idle, the block drives column strobes low for one cycle, then column and row strobes low, held while cfg_self_ref stays 1. After it clears, ras_n stays low for one cycle with column strobes high, then all strobes are released.
- R12: In idle, a self-refresh request wins over a pending refresh, which wins over an access request. A request present during self-refresh gets no ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until ack |
| req_area | input | 1 | DRAM area select |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables |
| req_addr | input | 18 | Row in [17:8], column in [7:0] |
| cfg_strobe_mode | input | 1 | 0 = two column strobes and one write enable, 1 = one column strobe and two write strobes |
| cfg_q1_ext | input | 1 | Stretch row phase by one cycle |
| cfg_q4_ext | input | 1 | Stretch column-strobe phase by one cycle |
| cfg_page_en | input | 1 | Keep row open after an access |
| cfg_ref_en | input | 1 | Run refresh interval counter |
| cfg_ref_reload | input | 12 | Refresh interval reload value |
| cfg_self_ref | input | 1 | Enter and hold self-refresh |
| ack | output | 1 | One-cycle access completion |
| ras_n | output | 2 | Row strobe per area, active low |
| cas_lo_n | output | 2 | Low column strobe per area, active low |
| cas_hi_n | output | 2 | High column strobe (mode 0) or high write strobe (mode 1), active low |
| we_n | output | 2 | Write enable (mode 0) or low write strobe (mode 1), active low |
| dram_addr | output | 10 | Multiplexed row/column address |

## Verification
The assertions watch properties that hold on every cycle regardless of scenario. Column and write strobes of an access never appear without that area's row strobe. Both row strobes fall together only after all column strobes were already low. ack lasts one cycle with strobes released, and only refresh states hold both row strobes. Self-refresh holds while requested and wins over everything in idle. Exact phase counts, row and column address values, byte-lane strobe patterns in both wirings, page-hit shortcut versus miss precharge, and the refresh interval and its deferral behind an access are only visible through the directed scenarios of the bench.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_Q1,
    ST_Q1X,
    ST_Q2,
    ST_Q3,
    ST_Q4,
    ST_Q4X,
    ST_Q5,
    ST_OPEN,
    ST_PRE,
    ST_R1,
    ST_R2,
    ST_R3,
    ST_R4,
    ST_SRE,
    ST_SRH
  } seq_state_e;

  typedef enum logic {
    STRB_TWO_CAS = 1'b0,
    STRB_TWO_WR  = 1'b1
  } strobe_mode_e;

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  input  logic             clr,
  output logic             pend
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_d;
  logic             expire;

  assign expire = en && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend;
    if (!en) begin
      cnt_d = reload;
    end else if (expire) begin
      cnt_d = reload;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    if (clr) begin
      pend_d = 1'b0;
    end
    if (expire) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pend  <= pend_d;
    end
  end

endmodule

// File: rtl/dram_req_latch.sv
module dram_req_latch #(
  parameter int AREA_W = 1,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [AREA_W-1:0] in_area,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic              in_wr,
  input  logic [1:0]        in_be,
  output logic [AREA_W-1:0] cur_area,
  output logic [ROW_W-1:0]  cur_row,
  output logic [COL_W-1:0]  cur_col,
  output logic              cur_wr,
  output logic [1:0]        cur_be,
  output logic              hit
);

  assign hit = (in_area == cur_area) && (in_row == cur_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_area <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
      cur_wr   <= 1'b0;
      cur_be   <= '0;
    end else if (take) begin
      cur_area <= in_area;
      cur_row  <= in_row;
      cur_col  <= in_col;
      cur_wr   <= in_wr;
      cur_be   <= in_be;
    end
  end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       hit,
  input  logic       ref_pend,
  input  logic       self_req,
  input  logic       q1_ext,
  input  logic       q4_ext,
  input  logic       page_en,
  output seq_state_e state,
  output logic       take,
  output logic       ref_clr
);

  seq_state_e state_d;

  always_comb begin
    state_d = state;
    take    = 1'b0;
    ref_clr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (self_req) begin
          state_d = ST_SRE;
          ref_clr = 1'b1;
        end else if (ref_pend) begin
          state_d = ST_R1;
          ref_clr = 1'b1;
        end else if (req_valid) begin
          state_d = ST_Q1;
          take    = 1'b1;
        end
      end
      ST_Q1:  state_d = q1_ext ? ST_Q1X : ST_Q2;
      ST_Q1X: state_d = ST_Q2;
      ST_Q2:  state_d = ST_Q3;
      ST_Q3:  state_d = ST_Q4;
      ST_Q4:  state_d = q4_ext ? ST_Q4X : ST_Q5;
      ST_Q4X: state_d = ST_Q5;
      ST_Q5:  state_d = page_en ? ST_OPEN : ST_IDLE;
      ST_OPEN: begin
        if (self_req || ref_pend || !page_en) begin
          state_d = ST_PRE;
        end else if (req_valid) begin
          if (hit) begin
            state_d = ST_Q2;
            take    = 1'b1;
          end else begin
            state_d = ST_PRE;
          end
        end
      end
      ST_PRE: state_d = ST_IDLE;
      ST_R1:  state_d = ST_R2;
      ST_R2:  state_d = ST_R3;
      ST_R3:  state_d = ST_R4;
      ST_R4:  state_d = ST_IDLE;
      ST_SRE: state_d = ST_SRH;
      ST_SRH: state_d = self_req ? ST_SRH : ST_R3;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive
  import dram_pkg::*;
#(
  parameter int NUM_AREA = 2,
  parameter int AREA_W   = 1,
  parameter int ROW_W    = 10,
  parameter int COL_W    = 8,
  parameter int MUX_W    = 10
) (
  input  seq_state_e          state,
  input  logic [AREA_W-1:0]   cur_area,
  input  logic [ROW_W-1:0]    cur_row,
  input  logic [COL_W-1:0]    cur_col,
  input  logic                cur_wr,
  input  logic [1:0]          cur_be,
  input  logic                mode,
  output logic [NUM_AREA-1:0] ras_n,
  output logic [NUM_AREA-1:0] cas_lo_n,
  output logic [NUM_AREA-1:0] cas_hi_n,
  output logic [NUM_AREA-1:0] we_n,
  output logic [MUX_W-1:0]    addr,
  output logic                ack
);

  logic row_ph, col_ph, cas_ph, ref_cas, ref_ras;

  assign row_ph  = state inside {ST_Q1, ST_Q1X, ST_OPEN};
  assign col_ph  = state inside {ST_Q2, ST_Q3, ST_Q4, ST_Q4X, ST_Q5};
  assign cas_ph  = state inside {ST_Q3, ST_Q4, ST_Q4X};
  assign ref_cas = state inside {ST_R1, ST_R2, ST_SRE, ST_SRH};
  assign ref_ras = state inside {ST_R2, ST_R3, ST_SRH};
  assign ack     = (state == ST_Q5);

  always_comb begin
    if (row_ph) begin
      addr = MUX_W'(cur_row);
    end else if (col_ph) begin
      addr = MUX_W'(cur_col);
    end else begin
      addr = '0;
    end
  end

  for (genvar a = 0; a < NUM_AREA; a++) begin : g_area
    logic sel, acc_cas, lo_on, hi_on, we_on;
    assign sel     = (cur_area == AREA_W'(a));
    assign acc_cas = sel & cas_ph;
    always_comb begin
      if (mode == STRB_TWO_WR) begin
        lo_on = acc_cas | ref_cas;
        hi_on = acc_cas & cur_wr & cur_be[1];
        we_on = acc_cas & cur_wr & cur_be[0];
      end else begin
        lo_on = (acc_cas & cur_be[0]) | ref_cas;
        hi_on = (acc_cas & cur_be[1]) | ref_cas;
        we_on = acc_cas & cur_wr;
      end
    end
    assign ras_n[a]    = ~((sel & (row_ph | col_ph)) | ref_ras);
    assign cas_lo_n[a] = ~lo_on;
    assign cas_hi_n[a] = ~hi_on;
    assign we_n[a]     = ~we_on;
  end

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_pkg::*;
#(
  parameter  int NUM_AREA = 2,
  parameter  int ROW_W    = 10,
  parameter  int COL_W    = 8,
  parameter  int REF_W    = 12,
  localparam int AREA_W   = (NUM_AREA > 1) ? $clog2(NUM_AREA) : 1,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int MUX_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AREA_W-1:0]   req_area,
  input  logic                req_write,
  input  logic [1:0]          req_be,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                cfg_strobe_mode,
  input  logic                cfg_q1_ext,
  input  logic                cfg_q4_ext,
  input  logic                cfg_page_en,
  input  logic                cfg_ref_en,
  input  logic [REF_W-1:0]    cfg_ref_reload,
  input  logic                cfg_self_ref,
  output logic                ack,
  output logic [NUM_AREA-1:0] ras_n,
  output logic [NUM_AREA-1:0] cas_lo_n,
  output logic [NUM_AREA-1:0] cas_hi_n,
  output logic [NUM_AREA-1:0] we_n,
  output logic [MUX_W-1:0]    dram_addr
);

  logic              rst_meta_n, rst_q_n;
  seq_state_e        cur_st;
  logic              take, ref_clr, ref_pend, hit;
  logic [AREA_W-1:0] cur_area;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_wr;
  logic [1:0]        cur_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  dram_ref_timer #(.CNT_W(REF_W)) u_ref (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .en     (cfg_ref_en),
    .reload (cfg_ref_reload),
    .clr    (ref_clr),
    .pend   (ref_pend)
  );

  dram_req_latch #(.AREA_W(AREA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .take     (take),
    .in_area  (req_area),
    .in_row   (req_addr[ADDR_W-1:COL_W]),
    .in_col   (req_addr[COL_W-1:0]),
    .in_wr    (req_write),
    .in_be    (req_be),
    .cur_area (cur_area),
    .cur_row  (cur_row),
    .cur_col  (cur_col),
    .cur_wr   (cur_wr),
    .cur_be   (cur_be),
    .hit      (hit)
  );

  dram_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .req_valid (req_valid),
    .hit       (hit),
    .ref_pend  (ref_pend),
    .self_req  (cfg_self_ref),
    .q1_ext    (cfg_q1_ext),
    .q4_ext    (cfg_q4_ext),
    .page_en   (cfg_page_en),
    .state     (cur_st),
    .take      (take),
    .ref_clr   (ref_clr)
  );

  dram_pin_drive #(
    .NUM_AREA (NUM_AREA),
    .AREA_W   (AREA_W),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .MUX_W    (MUX_W)
  ) u_pins (
    .state    (cur_st),
    .cur_area (cur_area),
    .cur_row  (cur_row),
    .cur_col  (cur_col),
    .cur_wr   (cur_wr),
    .cur_be   (cur_be),
    .mode     (cfg_strobe_mode),
    .ras_n    (ras_n),
    .cas_lo_n (cas_lo_n),
    .cas_hi_n (cas_hi_n),
    .we_n     (we_n),
    .addr     (dram_addr),
    .ack      (ack)
  );

endmodule

// File: rtl/dram_seq_ctrl_chk.sv
module dram_seq_ctrl_chk
  import dram_pkg::*;
#(
  parameter int NUM_AREA = 2
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                ack,
  input logic                cfg_self_ref,
  input logic [NUM_AREA-1:0] ras_n,
  input logic [NUM_AREA-1:0] cas_lo_n,
  input logic [NUM_AREA-1:0] cas_hi_n,
  input logic [NUM_AREA-1:0] we_n,
  input seq_state_e          cur_st
);

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack |=> !ack);

  // R2
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack |-> (cas_lo_n == '1 && cas_hi_n == '1 && we_n == '1));

  // R2
  single_ras_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($countones(~ras_n) > 1) |-> (cur_st inside {ST_R2, ST_R3, ST_SRH}));

  // R5
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (((~cas_lo_n) & ras_n) != '0) |-> (cas_lo_n == '0));

  // R6
  we_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (we_n != '1) |-> (((~we_n) & ras_n) == '0));

  // R9
  cas_first_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(ras_n) == '1 && ras_n == '0) |-> ($past(cas_lo_n) == '0));

  // R11
  self_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cur_st == ST_SRH && cfg_self_ref) |=> (ras_n == '0 && cas_lo_n == '0));

  // R12
  self_first_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cur_st == ST_IDLE && cfg_self_ref) |=> (cur_st == ST_SRE));

endmodule

bind dram_seq_ctrl dram_seq_ctrl_chk #(.NUM_AREA(NUM_AREA)) chk_i (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .ack          (ack),
  .cfg_self_ref (cfg_self_ref),
  .ras_n        (ras_n),
  .cas_lo_n     (cas_lo_n),
  .cas_hi_n     (cas_hi_n),
  .we_n         (we_n),
  .cur_st       (cur_st)
);

// File: tb/dram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_seq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_area, req_write;
  logic [1:0]  req_be;
  logic [17:0] req_addr;
  logic        cfg_strobe_mode, cfg_q1_ext, cfg_q4_ext, cfg_page_en;
  logic        cfg_ref_en, cfg_self_ref;
  logic [11:0] cfg_ref_reload;
  logic        ack;
  logic [1:0]  ras_n, cas_lo_n, cas_hi_n, we_n;
  logic [9:0]  dram_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dram_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_area(req_area),
    .req_write(req_write), .req_be(req_be), .req_addr(req_addr),
    .cfg_strobe_mode(cfg_strobe_mode), .cfg_q1_ext(cfg_q1_ext),
    .cfg_q4_ext(cfg_q4_ext), .cfg_page_en(cfg_page_en), .cfg_ref_en(cfg_ref_en),
    .cfg_ref_reload(cfg_ref_reload), .cfg_self_ref(cfg_self_ref), .ack(ack),
    .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .we_n(we_n),
    .dram_addr(dram_addr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] area_low(int area);
    logic [1:0] v = 2'b11;
    v[area] = 1'b0;
    return v;
  endfunction

  // Expected {cas_lo_n, cas_hi_n, we_n} during column-strobe cycles (R5, R6)
  function automatic logic [5:0] exp_strb(int area, bit mode, bit wr, logic [1:0] be);
    logic [1:0] lo = 2'b11, hi = 2'b11, we = 2'b11;
    if (!mode) begin
      lo[area] = ~be[0];
      hi[area] = ~be[1];
      we[area] = ~wr;
    end else begin
      lo[area] = 1'b0;
      hi[area] = ~(wr & be[1]);
      we[area] = ~(wr & be[0]);
    end
    return {lo, hi, we};
  endfunction

  task automatic run_access(string tag, int area, int row, int col, bit wr,
                            logic [1:0] be, int pre, bit hit);
    @(negedge clk);
    req_valid = 1'b1;
    req_area  = area[0];
    req_write = wr;
    req_be    = be;
    req_addr  = {row[9:0], col[7:0]};
    for (int i = 0; i < pre; i++) begin
      @(negedge clk);
      chk({tag, " precharge ras"}, ras_n, 2'b11);
    end
    if (!hit) begin
      for (int i = 0; i < 1 + int'(cfg_q1_ext); i++) begin
        @(negedge clk);
        chk({tag, " row ras"}, ras_n, area_low(area));
        chk({tag, " row addr"}, dram_addr, row);
        chk({tag, " row cas"}, cas_lo_n, 2'b11);
      end
    end
    @(negedge clk);
    chk({tag, " col ras"}, ras_n, area_low(area));
    chk({tag, " col addr"}, dram_addr, col);
    chk({tag, " col cas"}, {cas_lo_n, cas_hi_n, we_n}, 6'h3f);
    chk({tag, " col ack"}, ack, 0);
    for (int i = 0; i < 2 + int'(cfg_q4_ext); i++) begin
      @(negedge clk);
      chk({tag, " strobe ras"}, ras_n, area_low(area));
      chk({tag, " strobe addr"}, dram_addr, col);
      chk({tag, " strobes"}, {cas_lo_n, cas_hi_n, we_n},
          exp_strb(area, cfg_strobe_mode, wr, be));
      chk({tag, " strobe ack"}, ack, 0);
    end
    @(negedge clk);
    chk({tag, " ack"}, ack, 1);
    chk({tag, " ack strobes"}, {cas_lo_n, cas_hi_n, we_n}, 6'h3f);
    chk({tag, " ack ras"}, ras_n, area_low(area));
    req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " after ras"}, ras_n, cfg_page_en ? area_low(area) : 2'b11);
    chk({tag, " after ack"}, ack, 0);
  endtask

  // R9 refresh pattern from its first cycle, mode given by cfg_strobe_mode
  task automatic check_refresh_body(string tag);
    logic [1:0] hi_exp = cfg_strobe_mode ? 2'b11 : 2'b00;
    chk({tag, " c1 ras"}, ras_n, 2'b11);
    chk({tag, " c1 cas"}, {cas_lo_n, cas_hi_n}, {2'b00, hi_exp});
    @(negedge clk);
    chk({tag, " c2 ras"}, ras_n, 2'b00);
    chk({tag, " c2 cas"}, {cas_lo_n, cas_hi_n}, {2'b00, hi_exp});
    @(negedge clk);
    chk({tag, " c3 ras"}, ras_n, 2'b00);
    chk({tag, " c3 cas"}, {cas_lo_n, cas_hi_n}, 4'hf);
    @(negedge clk);
    chk({tag, " c4 all"}, {ras_n, cas_lo_n, cas_hi_n, we_n}, 8'hff);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 0; req_area = 0; req_write = 0; req_be = 0; req_addr = 0;
    cfg_strobe_mode = 0; cfg_q1_ext = 0; cfg_q4_ext = 0; cfg_page_en = 0;
    cfg_ref_en = 0; cfg_ref_reload = 12'd5; cfg_self_ref = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {ras_n, cas_lo_n, cas_hi_n, we_n}, 8'hff);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 strobes", {ras_n, cas_lo_n, cas_hi_n, we_n}, 8'hff);
    chk("R1 ack", ack, 0);
    chk("R1 addr", dram_addr, 0);
  endtask

  task automatic t_mode0();
    cfg_strobe_mode = 0; cfg_page_en = 0;
    run_access("R2 R5 read a0", 0, 10'h2a5, 8'h3c, 0, 2'b11, 0, 0);
    cfg_q1_ext = 1; cfg_q4_ext = 1;
    run_access("R3 R4 R5 write a1", 1, 10'h155, 8'hc3, 1, 2'b01, 0, 0);
    cfg_q1_ext = 0;
    run_access("R4 R5 write a0 hi", 0, 10'h001, 8'h80, 1, 2'b10, 0, 0);
    cfg_q4_ext = 0;
  endtask

  task automatic t_mode1();
    cfg_strobe_mode = 1;
    run_access("R6 write a0 hi", 0, 10'h3ff, 8'h11, 1, 2'b10, 0, 0);
    run_access("R6 write a1 lo", 1, 10'h070, 8'h22, 1, 2'b01, 0, 0);
    run_access("R6 read a1", 1, 10'h071, 8'h33, 0, 2'b01, 0, 0);
    cfg_strobe_mode = 0;
  endtask

  task automatic t_page();
    cfg_page_en = 1;
    run_access("R7 open a0", 0, 10'h005, 8'h01, 0, 2'b11, 0, 0);
    run_access("R7 hit a0", 0, 10'h005, 8'h02, 1, 2'b11, 0, 1);
    run_access("R8 miss row", 0, 10'h006, 8'h03, 0, 2'b11, 2, 0);
    run_access("R8 miss area", 1, 10'h006, 8'h04, 1, 2'b01, 2, 0);
    @(negedge clk);
    cfg_page_en = 0;
    @(negedge clk);
    chk("R8 close ras", ras_n, 2'b11);
    @(negedge clk);
    chk("R8 close idle ras", ras_n, 2'b11);
  endtask

  task automatic t_refresh_basic();
    int n = 0;
    @(negedge clk);
    cfg_ref_en = 0; cfg_ref_reload = 12'd5;
    @(negedge clk);
    cfg_ref_en = 1;
    do begin
      @(negedge clk);
      n++;
    end while (cas_lo_n != 2'b00 && n < 50);
    cfg_ref_en = 0;
    chk("R9 interval", n, 7);
    check_refresh_body("R9 basic");
    @(negedge clk);
    chk("R9 no repeat", {ras_n, cas_lo_n}, 4'hf);
  endtask

  task automatic t_refresh_defer();
    @(negedge clk);
    cfg_strobe_mode = 1; cfg_page_en = 1; cfg_ref_reload = 12'd3; cfg_ref_en = 0;
    @(negedge clk);
    cfg_ref_en = 1;
    run_access("R10 access", 0, 10'h123, 8'h45, 0, 2'b11, 0, 0);
    cfg_ref_en = 0;
    @(negedge clk);
    chk("R10 page close", ras_n, 2'b11);
    chk("R10 no early cas", cas_lo_n, 2'b11);
    @(negedge clk);
    chk("R10 precharge 2", {ras_n, cas_lo_n}, 4'hf);
    @(negedge clk);
    check_refresh_body("R9 R10 mode1");
    @(negedge clk);
    chk("R10 idle after", {ras_n, cas_lo_n, cas_hi_n}, 6'h3f);
    cfg_strobe_mode = 0; cfg_page_en = 0;
  endtask

  task automatic t_self();
    @(negedge clk);
    cfg_self_ref = 1;
    req_valid = 1; req_area = 0; req_write = 0; req_be = 2'b11; req_addr = 18'h00abc;
    @(negedge clk);
    chk("R11 R12 entry cas", {cas_lo_n, cas_hi_n}, 4'h0);
    chk("R11 R12 entry ras", ras_n, 2'b11);
    chk("R12 entry ack", ack, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R11 hold", {ras_n, cas_lo_n, cas_hi_n}, 6'h00);
      chk("R12 no ack", ack, 0);
    end
    cfg_self_ref = 0;
    req_valid = 0;
    @(negedge clk);
    chk("R11 exit ras", ras_n, 2'b00);
    chk("R11 exit cas", {cas_lo_n, cas_hi_n}, 4'hf);
    @(negedge clk);
    chk("R11 released", {ras_n, cas_lo_n, cas_hi_n, we_n}, 8'hff);
    @(negedge clk);
    chk("R12 stays idle", {ras_n, ack}, 3'b110);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mode0();
    t_mode1();
    t_page();
    t_refresh_basic();
    t_refresh_defer();
    t_self();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule